// File: doc/BRIEF.md
# Commit-Synchronised Clock Divider Bank

This block produces eleven divided clock-enable streams from a single fast reference clock. Each stream pulses high for exactly one reference cycle once every N cycles. N comes from a 4-bit code chosen through a fixed, non-linear ratio table. The codes live in two 32-bit control words that software reaches through a simple write port and a combinational read port.

Software stages new codes first. Each field checks its code against its own mask of permitted ratios and drops a code that is not allowed. A staged code has no effect on any output until software sets the commit flag. The hardware then waits for a reference cycle in which every divider is at its terminal count. In that cycle all eleven dividers reload with their staged ratios and the commit flag drops. No output ever sees a shortened or stretched period at the changeover. Software polls the flag to learn when the switch has happened.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the codes are: output0=1, output1=2, output2=0, output3=3, output4=2, output5=4, output6=1, output7=2, output8=5, output9=0, output10=3. The commit flag reads 0. Each output is active with its default code and gives its first pulse N-1 cycles after reset is released.
- R2: An output whose active code is c pulses for one cycle every N cycles. The mapping from code c to ratio N is: 12→7, 0→2, 1→3, 2→4, 3→6, 4→8, 5→12, 6→16, 7→18, 8→24, 10→36, 11→48. Code 9 is reserved.
- R3: Word 0 (select 0) holds outputs 0..5 at bit offsets 20, 16, 12, 8, 4, 0. Word 1 (select 1) holds outputs 6..10 at offsets 24, 20, 16, 12, 4 and the commit flag at bit 31. All other bits read 0.
- R4: A field accepts a written code only if bit c of its mask is set. Outputs 0, 3, 7, 8, 9 and 10 use mask 0xdff. Output 1 uses 0xd7f. Outputs 2, 4 and 5 use 0x1dff. Output 6 uses 0x97f. Any other code leaves the field's staged value unchanged, and this includes 9 and 13..15.
- R5: Reads return the staged codes. A staged code that differs from the active one does not change any output until a commit takes place.
- R6: Writing word 1 with bit 31 set raises the commit flag, and the flag reads 1 from the next cycle. A later write with bit 31 clear does not cancel a raised flag.
- R7: A raised flag is acted on only at the clock edge that ends a cycle in which every output pulses together. At that edge the flag clears, and every output begins a full period of its new ratio.
- R8: At a commit, all eleven active codes take their staged values in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control words |
| wr_sel | input | 1 | Word selected for writing (0 or 1) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word selected for reading |
| rd_data | output | 32 | Staged codes and the commit flag of the selected word |
| div_pulse | output | 11 | One-cycle enable pulse per output |

## Verification
The case that is hardest to reach is a commit that waits a long time for a common terminal cycle while software keeps writing. The stimulus sets up ratios 7, 16 and 18 together, which gives a 1008-cycle alignment period. A write that clears bit 31 lands while the flag is still up, and random writes mix legal, masked-out and reserved codes in every field before each commit. The bench compares every output on every cycle against its own model. At each flag drop it also confirms that the cycle just before had all eleven pulses high.

// File: rtl/clkdiv_pkg.sv
// Shared constants, types and field tables for the divider bank.
// Assumes eleven outputs split across two 32-bit control words.
package clkdiv_pkg;

    localparam int NUM_OUT   = 11;
    localparam int CODE_W    = 4;
    localparam int REG_W     = 32;
    localparam int KICK_BIT  = REG_W - 1;
    localparam int MAX_RATIO = 48;
    localparam int CNT_W     = $clog2(MAX_RATIO);
    localparam int MASK_W    = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [MASK_W-1:0] mask_t;

    // Ratio minus one for a code; the reserved code never reaches a counter.
    function automatic cnt_t ratio_m1(code_t c);
        case (c)
            4'd0:    return cnt_t'(1);
            4'd1:    return cnt_t'(2);
            4'd2:    return cnt_t'(3);
            4'd3:    return cnt_t'(5);
            4'd4:    return cnt_t'(7);
            4'd5:    return cnt_t'(11);
            4'd6:    return cnt_t'(15);
            4'd7:    return cnt_t'(17);
            4'd8:    return cnt_t'(23);
            4'd10:   return cnt_t'(35);
            4'd11:   return cnt_t'(47);
            4'd12:   return cnt_t'(6);
            default: return cnt_t'(1);
        endcase
    endfunction

    // Word that carries output i.
    function automatic logic field_sel(int i);
        return (i >= 6);
    endfunction

    // Lowest bit of the field of output i within its word.
    function automatic int field_lsb(int i);
        case (i)
            0: return 20;
            1: return 16;
            2: return 12;
            3: return 8;
            4: return 4;
            5: return 0;
            6: return 24;
            7: return 20;
            8: return 16;
            9: return 12;
            default: return 4;
        endcase
    endfunction

    // Permitted-code mask of output i.
    function automatic mask_t field_mask(int i);
        case (i)
            1:       return mask_t'(16'h0d7f);
            2, 4, 5: return mask_t'(16'h1dff);
            6:       return mask_t'(16'h097f);
            default: return mask_t'(16'h0dff);
        endcase
    endfunction

    // Reset code of output i.
    function automatic code_t field_default(int i);
        case (i)
            0, 6:    return code_t'(1);
            1, 4, 7: return code_t'(2);
            3, 10:   return code_t'(3);
            5:       return code_t'(4);
            8:       return code_t'(5);
            default: return code_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/clkdiv_shadow_regs.sv
// Staged code fields, mask filtering of writes, and the commit flag.
// Assumes a single-cycle write strobe; the read path is combinational.
module clkdiv_shadow_regs
    import clkdiv_pkg::*;
#(
    parameter int N_OUT  = NUM_OUT,
    parameter int DATA_W = REG_W,
    parameter int CW     = CODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      rd_sel,
    input  logic                      commit,
    output logic [N_OUT-1:0][CW-1:0]  shadow_o,
    output logic                      pending_o,
    output logic [DATA_W-1:0]         rd_data
);

    localparam int FLAG_BIT = DATA_W - 1;

    genvar g;
    generate
        for (g = 0; g < N_OUT; g++) begin : g_field
            localparam int    LSB  = field_lsb(g);
            localparam logic  SEL  = field_sel(g);
            localparam mask_t MASK = field_mask(g);
            logic [CW-1:0] sh_q;
            logic [CW-1:0] wcode;

            assign wcode = wr_data[LSB +: CW];

            // Accept a written code only if the field's mask allows it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q <= field_default(g);
                end else if (wr_en && (wr_sel == SEL) && MASK[wcode]) begin
                    sh_q <= wcode;
                end
            end

            assign shadow_o[g] = sh_q;
        end
    endgenerate

    // Commit flag: a new request wins over the clear of a finishing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_o <= 1'b0;
        end else if (wr_en && wr_sel && wr_data[FLAG_BIT]) begin
            pending_o <= 1'b1;
        end else if (commit) begin
            pending_o <= 1'b0;
        end
    end

    // Assemble the selected word from staged fields and the flag.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_OUT; i++) begin
            if (field_sel(i) == rd_sel) begin
                rd_data[field_lsb(i) +: CW] = shadow_o[i];
            end
        end
        if (rd_sel) begin
            rd_data[FLAG_BIT] = pending_o;
        end
    end

endmodule

// File: rtl/clkdiv_commit_ctrl.sv
// Holds the active codes and decides the commit cycle.
// Assumes all counters reload together, so common terminal cycles recur.
module clkdiv_commit_ctrl
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = NUM_OUT,
    parameter int CW    = CODE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pending,
    input  logic [N_OUT-1:0]          term_vec,
    input  logic [N_OUT-1:0][CW-1:0]  shadow,
    output logic                      commit_o,
    output logic [N_OUT-1:0][CW-1:0]  active_o
);

    // Commit only when a request waits and every divider is at its terminal count.
    assign commit_o = pending && (&term_vec);

    genvar g;
    generate
        for (g = 0; g < N_OUT; g++) begin : g_act
            // Take the staged code at the commit edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    active_o[g] <= field_default(g);
                end else if (commit_o) begin
                    active_o[g] <= shadow[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_counter.sv
// Down-counter for one output; pulses while at zero and then reloads.
// Assumes codes reaching it are permitted and that the reload at a commit uses the staged code.
module clkdiv_counter
    import clkdiv_pkg::*;
#(
    parameter int    CW         = CODE_W,
    parameter int    CNTW       = CNT_W,
    parameter code_t RESET_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [CW-1:0] cur_code,
    input  logic [CW-1:0] nxt_code,
    output logic          term_o
);

    logic [CNTW-1:0] cnt_q;

    assign term_o = (cnt_q == '0);

    // Count down and reload at zero, with the new ratio when committing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ratio_m1(RESET_CODE);
        end else if (term_o) begin
            cnt_q <= ratio_m1(commit ? nxt_code : cur_code);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
// Top level: eleven divided clock enables with a staged, commit-synchronised ratio update.
// Assumes one reference clock domain; pulses are enables, not clocks.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int N_OUT  = NUM_OUT,
    parameter int DATA_W = REG_W,
    parameter int CW     = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_OUT-1:0]  div_pulse
);

    logic [N_OUT-1:0][CW-1:0] shadow_codes;
    logic [N_OUT-1:0][CW-1:0] active_codes;
    logic                     kick_pending;
    logic                     commit;
    logic [N_OUT-1:0]         term_vec;

    clkdiv_shadow_regs #(.N_OUT(N_OUT), .DATA_W(DATA_W), .CW(CW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .commit   (commit),
        .shadow_o (shadow_codes),
        .pending_o(kick_pending),
        .rd_data  (rd_data)
    );

    clkdiv_commit_ctrl #(.N_OUT(N_OUT), .CW(CW)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (kick_pending),
        .term_vec(term_vec),
        .shadow  (shadow_codes),
        .commit_o(commit),
        .active_o(active_codes)
    );

    genvar g;
    generate
        for (g = 0; g < N_OUT; g++) begin : g_div
            clkdiv_counter #(.CW(CW), .CNTW(CNT_W), .RESET_CODE(field_default(g))) cnt_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .commit  (commit),
                .cur_code(active_codes[g]),
                .nxt_code(shadow_codes[g]),
                .term_o  (term_vec[g])
            );
        end
    endgenerate

    assign div_pulse = term_vec;

endmodule

// File: rtl/clkdiv_bank_checker.sv
// Assertion checker bound to the divider bank top.
// Assumes the signal names of the top level.
module clkdiv_bank_checker
    import clkdiv_pkg::*;
#(
    parameter int N_OUT = NUM_OUT,
    parameter int CW    = CODE_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pending,
    input logic [N_OUT-1:0]         div_pulse,
    input logic [N_OUT-1:0][CW-1:0] active,
    input logic [N_OUT-1:0][CW-1:0] shadow
);

    // The flag drops only after a cycle with every output pulsing.
    assert_kick_clears_on_common_edge_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(&div_pulse)
    );

    // Active codes move only at a commit edge.
    assert_active_moves_only_on_commit_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> ($past(pending) && $past(&div_pulse))
    );

    // At a commit, every active code takes its staged value together.
    assert_all_switch_together_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> (active == $past(shadow))
    );

    genvar g;
    generate
        for (g = 0; g < N_OUT; g++) begin : g_chk
            localparam mask_t MASK = field_mask(g);

            // Staged codes are always permitted.
            assert_shadow_permitted_R4: assert property (
                @(posedge clk) disable iff (!rst_n)
                MASK[shadow[g]]
            );

            // Every ratio is at least two, so a pulse never lasts two cycles.
            assert_pulse_single_cycle_R2: assert property (
                @(posedge clk) disable iff (!rst_n)
                div_pulse[g] |=> !div_pulse[g]
            );
        end
    endgenerate

endmodule

bind clkdiv_bank clkdiv_bank_checker #(.N_OUT(N_OUT), .CW(CW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (kick_pending),
    .div_pulse(div_pulse),
    .active   (active_codes),
    .shadow   (shadow_codes)
);

// File: tb/clkdiv_bank_tb_top.sv
// Self-checking bench: a cycle model built from the requirements, directed cases and seeded random writes.
module clkdiv_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NO = 11;

    localparam int      B_LSB  [NO] = '{20, 16, 12, 8, 4, 0, 24, 20, 16, 12, 4};
    localparam bit      B_SEL  [NO] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1};
    localparam bit [15:0] B_MASK [NO] = '{16'h0dff, 16'h0d7f, 16'h1dff, 16'h0dff, 16'h1dff,
                                         16'h1dff, 16'h097f, 16'h0dff, 16'h0dff, 16'h0dff, 16'h0dff};
    localparam int      B_DEF  [NO] = '{1, 2, 0, 3, 2, 4, 1, 2, 5, 0, 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [NO-1:0] div_pulse;

    int checks = 0;
    int errors = 0;
    int cmp_fails_shown = 0;

    int m_shadow [NO];
    int m_active [NO];
    int m_phase  [NO];
    bit m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .div_pulse(div_pulse)
    );

    function automatic int b_ratio(int c);
        case (c)
            0: return 2;   1: return 3;   2: return 4;   3: return 6;
            4: return 8;   5: return 12;  6: return 16;  7: return 18;
            8: return 24;  10: return 36; 11: return 48; 12: return 7;
            default: return 2;
        endcase
    endfunction

    function automatic bit all_phase_zero();
        for (int i = 0; i < NO; i++) if (m_phase[i] != 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] model_read(bit sel);
        logic [31:0] v = '0;
        for (int i = 0; i < NO; i++)
            if (B_SEL[i] == sel) v[B_LSB[i] +: 4] = 4'(m_shadow[i]);
        if (sel) v[31] = m_pend;
        return v;
    endfunction

    // Reference model of the bank, advanced on every clock edge.
    always @(posedge clk) begin : model
        bit cm;
        logic [3:0] wc;
        if (!rst_n) begin
            for (int i = 0; i < NO; i++) begin
                m_shadow[i] <= B_DEF[i];
                m_active[i] <= B_DEF[i];
                m_phase[i]  <= b_ratio(B_DEF[i]) - 1;
            end
            m_pend <= 1'b0;
        end else begin
            cm = m_pend && all_phase_zero();
            for (int i = 0; i < NO; i++) begin
                if (m_phase[i] == 0)
                    m_phase[i] <= b_ratio(cm ? m_shadow[i] : m_active[i]) - 1;
                else
                    m_phase[i] <= m_phase[i] - 1;
            end
            if (cm) begin
                for (int i = 0; i < NO; i++) m_active[i] <= m_shadow[i];
                m_pend <= 1'b0;
            end
            if (wr_en) begin
                for (int i = 0; i < NO; i++) begin
                    wc = wr_data[B_LSB[i] +: 4];
                    if (B_SEL[i] == wr_sel && B_MASK[i][wc]) m_shadow[i] <= int'(wc);
                end
                if (wr_sel && wr_data[31]) m_pend <= 1'b1;
            end
        end
    end

    // Cycle-by-cycle pulse comparison (R2, R7 timing).
    always @(negedge clk) begin : pulse_cmp
        logic [NO-1:0] exp_p;
        if (rst_n) begin
            for (int i = 0; i < NO; i++) exp_p[i] = (m_phase[i] == 0);
            checks++;
            if (div_pulse !== exp_p) begin
                errors++;
                if (cmp_fails_shown < 10) begin
                    cmp_fails_shown++;
                    $display("FAIL R2/R7 pulse vector at %0t actual %b expected %b", $time, div_pulse, exp_p);
                end
            end
        end
    end

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(bit sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_read(bit sel, string tag);
        rd_sel = sel;
        #1;
        check_val(tag, rd_data, model_read(sel));
    endtask

    task automatic count_pulses(int idx, int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            #1;
            if (div_pulse[idx]) n++;
        end
    endtask

    // Poll the commit flag; at the drop the previous sample must show all outputs pulsing.
    task automatic wait_commit(string tag);
        logic [NO-1:0] last_pv;
        bit done = 1'b0;
        rd_sel = 1'b1;
        #1;
        last_pv = div_pulse;
        for (int k = 0; k < 3000 && !done; k++) begin
            @(negedge clk);
            #1;
            if (!rd_data[31]) begin
                done = 1'b1;
                check_val({tag, " R7 all pulses before flag drop"}, 32'(last_pv), 32'({NO{1'b1}}));
            end
            last_pv = div_pulse;
        end
        if (!done) check_val({tag, " R7 flag never cleared"}, 32'(1), 32'(0));
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n;
        int seed;
        seed = 32'h5eed1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        // R1 / R3: reset values at fixed positions.
        rd_sel = 1'b0; #1;
        check_val("R1 R3 word0 reset", rd_data, 32'h0012_0324);
        rd_sel = 1'b1; #1;
        check_val("R1 R3 word1 reset", rd_data, 32'h0125_0030);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: output2 (ratio 2) first pulse one cycle after release.
        count_pulses(2, 1, n);
        check_val("R1 output2 first pulse", 32'(n), 32'd1);
        count_pulses(8, 36, n);
        check_val("R1 output8 ratio 12 pulses", 32'(n), 32'd3);

        // R4: reserved and masked-out codes are ignored.
        write_reg(1'b0, 32'h9999_9999);
        check_read(1'b0, "R4 reserved codes word0");
        check_val("R4 word0 unchanged", rd_data, 32'h0012_0324);
        write_reg(1'b0, 32'h0017_0324);
        check_read(1'b0, "R4 code7 rejected by output1");
        check_val("R4 output1 keeps 2", rd_data, 32'h0012_0324);
        write_reg(1'b1, 32'h0A25_00F0);
        check_read(1'b1, "R4 code10 and 15 rejected word1");
        check_val("R4 word1 unchanged", rd_data, 32'h0125_0030);

        // R5: staged codes read back but do not act before a commit.
        write_reg(1'b0, 32'h0012_C326);
        check_read(1'b0, "R5 staged word0");
        check_val("R5 staged word0 value", rd_data, 32'h0012_C326);
        count_pulses(2, 42, n);
        check_val("R5 output2 still ratio 2", 32'(n), 32'd21);

        // R6: commit request; a later write without bit 31 does not cancel.
        write_reg(1'b1, 32'h8127_0030);
        rd_sel = 1'b1; #1;
        check_val("R6 flag set", 32'(rd_data[31]), 32'd1);
        write_reg(1'b1, 32'h0127_0030);
        rd_sel = 1'b1; #1;
        check_val("R6 flag not cancelled", 32'(rd_data[31]), 32'd1);
        wait_commit("directed");
        check_read(1'b1, "R8 word1 after commit");
        // R2 / R8: new ratios apply to all outputs.
        count_pulses(2, 70, n);
        check_val("R2 output2 ratio 7", 32'(n), 32'd10);
        count_pulses(5, 64, n);
        check_val("R8 output5 ratio 16", 32'(n), 32'd4);

        // Random mix of legal, masked and reserved codes with commits.
        for (int it = 0; it < 30; it++) begin
            bit sel;
            logic [31:0] d;
            sel = 1'($urandom_range(0, 1));
            d = $urandom();
            write_reg(sel, d);
            check_read(sel, "R4 R5 random staged read");
            if (sel && d[31]) wait_commit("random");
            repeat ($urandom_range(0, 20)) @(negedge clk);
            check_read(1'b0, "R5 random word0");
            check_read(1'b1, "R6 random word1");
        end
        write_reg(1'b1, 32'h8000_0000);
        wait_commit("final");
        repeat (50) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule